// File: doc/BRIEF.md
# Type A Frame Checksum Appender

This block computes the 16-bit checksum that closes every NFC Type A frame. A producer streams the frame payload into it one byte per clock, using a valid/ready handshake. A start strobe marks the first byte and a last flag marks the final one. The block folds each accepted byte into a 16-bit register as it arrives.

Once the final byte has been absorbed, the block stops accepting input for two cycles. During those cycles it emits the checksum as a two-byte output stream, so a downstream serializer can append it directly after the payload. The low byte comes first. A done flag marks the cycle of the second byte. The register is then preset again, so the next frame starts from a clean state.

Top module: `crca_append`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, `out_valid_o` and `done_o` are 0 and `in_ready_o` is 1. The register holds the preset 0x6363, so a first frame sent without a start strobe yields the same checksum as one sent with it.
- R2: When `in_sof_i` is high together with an accepted byte, the register is preset before that byte is folded in.
- R3: When `in_sof_i` is high in a ready cycle with `in_valid_i` low, the register is preset, which discards anything folded in earlier.
- R4: Each accepted byte b updates the register c as follows. First t = (b XOR c[7:0]). Then t = t XOR (t << 4), kept to 8 bits. Finally c = (c >> 8) XOR (t << 8) XOR (t << 3) XOR (t >> 4), kept to 16 bits. The payload 0x00 0x00 therefore gives 0x1EA0.
- R5: Bytes are folded in the order they are accepted, so swapping two payload bytes changes the result as the R4 update predicts.
- R6: `in_ready_o` is 1 in every cycle except the two output cycles. A byte is accepted when `in_valid_i` and `in_ready_o` are both 1. Inputs presented while `in_ready_o` is 0 have no effect on the checksum.
- R7: In the cycle after the byte flagged by `in_last_i` is accepted, `out_valid_o` is 1 and `out_data_o` carries checksum bits [7:0]. In the following cycle it carries bits [15:8].
- R8: `done_o` is 1 only in the cycle of the high checksum byte. In the cycle after it, `out_valid_o` is 0 and `in_ready_o` is 1.
- R9: After the high byte is emitted the register is preset, so a following frame sent without a start strobe yields its correct checksum.
- R10: A one-byte frame, with start and last in the same cycle, yields the checksum of that single byte.
- R11: Cycles with `in_valid_i` low between accepted bytes leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_sof_i | input | 1 | Start-of-frame strobe; presets the register |
| in_valid_i | input | 1 | Input byte is valid |
| in_data_i | input | 8 | Input payload byte |
| in_last_i | input | 1 | Marks the final payload byte |
| in_ready_o | output | 1 | Block can accept a byte |
| out_valid_o | output | 1 | Checksum byte is valid |
| out_data_o | output | 8 | Checksum byte, low byte first |
| done_o | output | 1 | Pulses with the high checksum byte |

## Verification
The all-zero two-byte payload is checked against the fixed value 0x1EA0. This catches a wrong preset or a wrong shift in the update, which a model-only comparison could share with the design. The payloads 0x12 0x34 and 0x34 0x12 are both run to separate correct byte ordering from any order-blind fold. A one-byte frame, and a frame with idle gaps, separate the coincident-start path and the hold path from the plain streaming path. Frames sent without a start strobe, once after reset, once after a completed frame and once after a stray partial frame that is followed by a lone start strobe, tell the three preset sources apart. Junk bytes are driven during emission to show that they are ignored.

// File: rtl/crca_pkg.sv
package crca_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CRC_W  = 16;

  typedef enum logic [1:0] {
    ST_TAKE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } crca_state_e;

  // One byte of the reflected Type A update.
  function automatic logic [CRC_W-1:0] crca_step(input logic [CRC_W-1:0] c,
                                                 input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] t;
    logic [CRC_W-1:0]  tw;
    t  = b ^ c[BYTE_W-1:0];
    t  = t ^ (t << 4);
    tw = {{(CRC_W-BYTE_W){1'b0}}, t};
    return (c >> 8) ^ (tw << 8) ^ (tw << 3) ^ (tw >> 4);
  endfunction
endpackage

// File: rtl/crca_fold.sv
module crca_fold
  import crca_pkg::*;
#(
  parameter logic [CRC_W-1:0] PRESET = 16'h6363
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] base;

  assign base = load_i ? PRESET : crc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= PRESET;
    else if (take_i) crc_o <= crca_step(base, byte_i);
    else if (load_i) crc_o <= PRESET;
  end

  p_preset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !take_i) |=> (crc_o == PRESET));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !take_i) |=> $stable(crc_o));
endmodule

// File: rtl/crca_seq.sv
module crca_seq
  import crca_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic last_i,
  output logic ready_o,
  output logic emit_lo_o,
  output logic emit_hi_o
);
  crca_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_TAKE: if (take_i && last_i) st_d = ST_LO;
      ST_LO:   st_d = ST_HI;
      ST_HI:   st_d = ST_TAKE;
      default: st_d = ST_TAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_TAKE;
    else         st_q <= st_d;
  end

  assign ready_o   = (st_q == ST_TAKE);
  assign emit_lo_o = (st_q == ST_LO);
  assign emit_hi_o = (st_q == ST_HI);

  p_two_bytes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_lo_o |=> emit_hi_o);

  p_back_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_hi_o |=> ready_o);

  p_state_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({ready_o, emit_lo_o, emit_hi_o}));
endmodule

// File: rtl/crca_append.sv
module crca_append
  import crca_pkg::*;
#(
  parameter logic [CRC_W-1:0] PRESET = 16'h6363
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_sof_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              done_o
);
  logic             take, load, emit_lo, emit_hi;
  logic [CRC_W-1:0] crc;

  assign take = in_valid_i & in_ready_o;
  // Preset on an accepted start strobe, or as the frame closes.
  assign load = (in_sof_i & in_ready_o) | emit_hi;

  crca_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .last_i    (in_last_i),
    .ready_o   (in_ready_o),
    .emit_lo_o (emit_lo),
    .emit_hi_o (emit_hi)
  );

  crca_fold #(.PRESET(PRESET)) u_fold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .load_i (load),
    .byte_i (in_data_i),
    .crc_o  (crc)
  );

  assign out_valid_o = emit_lo | emit_hi;
  assign out_data_o  = emit_hi ? crc[CRC_W-1:BYTE_W] : crc[BYTE_W-1:0];
  assign done_o      = emit_hi;

  p_ready_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  p_last_emits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_last_i) |=> (out_valid_o && !done_o));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_second_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (out_valid_o && $past(out_valid_o)));

  p_stable_crc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !done_o) |=> (out_data_o == $past(crc[CRC_W-1:BYTE_W])));
endmodule

// File: tb/crca_append_bench.sv
module crca_append_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 1'b0, vld = 1'b0, last = 1'b0;
  logic [7:0] din = 8'h00;
  logic       rdy, ovld, done;
  logic [7:0] dout;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] pay [16];

  always #2 clk = ~clk;

  crca_append u_crca_append (
    .clk_i(clk), .rst_ni(rst_n), .in_sof_i(sof), .in_valid_i(vld),
    .in_data_i(din), .in_last_i(last), .in_ready_o(rdy),
    .out_valid_o(ovld), .out_data_o(dout), .done_o(done)
  );

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c;
    logic [7:0]  t;
    c = 16'h6363;
    for (int i = 0; i < n; i++) begin
      t = pay[i] ^ c[7:0];
      t = t ^ {t[3:0], 4'h0};
      c = {8'h00, c[15:8]} ^ {t, 8'h00} ^ {5'h00, t, 3'h0} ^ {12'h000, t[7:4]};
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Stream n bytes from pay[], then verify the two output cycles and the return to idle.
  task automatic run_frame(input string req, input int n, input bit use_sof,
                           input bit gaps, input logic [15:0] exp);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sof = use_sof && (i == 0); vld = 1'b1; din = pay[i]; last = (i == n - 1);
      if (gaps && i < n - 1) begin
        @(negedge clk);
        sof = 1'b0; vld = 1'b0; last = 1'b0; din = 8'hA5;
      end
    end
    @(negedge clk);
    // Junk during emission must be ignored (R6).
    sof = 1'b1; vld = 1'b1; din = 8'hFF; last = 1'b1;
    chk({req, " R7 lo valid"}, {15'd0, ovld}, 16'd1);
    chk({req, " R7 lo byte"}, {8'd0, dout}, {8'd0, exp[7:0]});
    chk({req, " R6 not ready"}, {15'd0, rdy}, 16'd0);
    chk({req, " R8 no early done"}, {15'd0, done}, 16'd0);
    @(negedge clk);
    chk({req, " R7 hi byte"}, {8'd0, dout}, {8'd0, exp[15:8]});
    chk({req, " R8 done"}, {14'd0, done, ovld}, 16'd3);
    sof = 1'b0; vld = 1'b0; last = 1'b0;
    @(negedge clk);
    chk({req, " R8 idle"}, {14'd0, ovld, done}, 16'd0);
    chk({req, " R8 ready"}, {15'd0, rdy}, 16'd1);
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", {13'd0, rdy, ovld, done}, 16'b100);
    pay[0] = 8'h12; pay[1] = 8'h34;
    run_frame("R1 no-sof after reset", 2, 1'b0, 1'b0, ref_crc(2));
  endtask

  task automatic t_zero();
    pay[0] = 8'h00; pay[1] = 8'h00;
    run_frame("R4 zero vector", 2, 1'b1, 1'b0, 16'h1EA0);
  endtask

  task automatic t_order();
    logic [15:0] a, b;
    pay[0] = 8'h12; pay[1] = 8'h34; a = ref_crc(2);
    run_frame("R2 R4 12 34", 2, 1'b1, 1'b0, a);
    pay[0] = 8'h34; pay[1] = 8'h12; b = ref_crc(2);
    chk("R5 order matters", {15'd0, a != b}, 16'd1);
    run_frame("R5 34 12", 2, 1'b1, 1'b0, b);
  endtask

  task automatic t_single();
    pay[0] = 8'hC3;
    run_frame("R10 single byte", 1, 1'b1, 1'b0, ref_crc(1));
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 6; i++) pay[i] = 8'(8'h1D * i + 8'h07);
    run_frame("R11 gapped", 6, 1'b1, 1'b1, ref_crc(6));
  endtask

  task automatic t_chain();
    pay[0] = 8'hE0; pay[1] = 8'h50;
    run_frame("R9 first", 2, 1'b1, 1'b0, ref_crc(2));
    pay[0] = 8'h93; pay[1] = 8'h20; pay[2] = 8'h70;
    run_frame("R9 second no-sof", 3, 1'b0, 1'b0, ref_crc(3));
  endtask

  task automatic t_lone_sof();
    // Partial frame left open, then a lone start strobe discards it.
    @(negedge clk); vld = 1'b1; din = 8'h5A; last = 1'b0; sof = 1'b1;
    @(negedge clk); din = 8'h77; sof = 1'b0;
    @(negedge clk); vld = 1'b0; sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    pay[0] = 8'hAB; pay[1] = 8'hCD;
    run_frame("R3 lone sof", 2, 1'b0, 1'b0, ref_crc(2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_order();
    t_single();
    t_gaps();
    t_chain();
    t_lone_sof();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule